// File: doc/BRIEF.md
# Reverse-Direction Parallel Port Receive FIFO Service

This block sits on the host side of a 16-byte receive FIFO for a parallel port that is running in its extended-capability reverse direction. The peripheral pushes bytes in through a write strobe. The host drains them in one of two ways. With DMA enabled, a request line stays up while data is waiting and drops on terminal count. With DMA disabled, a threshold interrupt tells software that a burst of bytes can be read.

A single service bit gates both paths. When a terminal count is accepted, the block sets this bit itself and raises a latched interrupt. Software clears the bit to re-arm the channel. The interrupt threshold is given as a 4-bit value `thr`, and the interrupt fires once the occupancy reaches 16 minus that value. The code 0 stands for 16, and 16 behaves exactly like 15.

Top module: `revFifoService`

## Requirements
- R1: After a synchronous reset (`rstN` low at a clock edge), `fillLevel` is 0, `hostData` is 0, and `dmaReq`, `intrOut` and `svcBit` are all 0.
- R2: The FIFO holds 16 bytes and returns them in first-in first-out order. A `periphWr` while `fillLevel` is below 16 raises `fillLevel` by one after the edge. A `periphWr` while `fillLevel` is 16 is dropped.
- R3: A `hostRd` while `fillLevel` is at least 1 puts the oldest byte on `hostData` after the edge and lowers `fillLevel` by one. A `hostRd` on an empty FIFO leaves both `hostData` and `fillLevel` unchanged.
- R4: `dmaReq` is high exactly when `dmaEn` is 1, `svcBit` is 0 and `fillLevel` is at least 1. It therefore drops when the FIFO empties and returns as soon as one byte arrives.
- R5: A terminal count is accepted at a clock edge when `dmaEn`, `termCnt` and `dmaAck` are all 1 and one of these holds: `dmaAck` was 0 at the previous edge (acknowledge edge), or `hostRd` is 1 (acknowledge held with no edge). After that edge `svcBit` is 1 and `dmaReq` is 0.
- R6: After a terminal-count drop, `dmaReq` stays low even while bytes arrive. It returns only once software writes `svcBit` to 0 while at least one byte is held.
- R7: With `dmaEn` 0 and `svcBit` 0, the threshold interrupt is high exactly when `fillLevel` is at least 16 minus `thr` (for `thr` 1 to 15). For example, `thr` = 12 interrupts at 4 to 16 bytes.
- R8: `thr` = 0 encodes 16 and is treated the same as 15, so the interrupt fires at 1 byte or more.
- R9: While `svcBit` is 1, the threshold interrupt is suppressed at every fill level.
- R10: An accepted terminal count sets a latched interrupt that holds `intrOut` high until software writes `svcBit` to 0. When a terminal count and a software write arrive at the same edge, the terminal count wins.
- R11: With `svcWe` high at an edge (and no terminal count), `svcBit` takes the value of `svcWd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| periphWr | input | 1 | Peripheral write strobe |
| periphData | input | 8 | Byte from the peripheral |
| hostRd | input | 1 | Host read strobe |
| hostData | output | 8 | Last byte read by the host |
| dmaEn | input | 1 | 1 selects DMA draining, 0 selects interrupt-driven programmed I/O |
| dmaAck | input | 1 | DMA acknowledge, active high |
| termCnt | input | 1 | DMA terminal count |
| svcWe | input | 1 | Software write enable for the service bit |
| svcWd | input | 1 | Value written to the service bit |
| thr | input | 4 | Interrupt threshold code (0 means 16) |
| dmaReq | output | 1 | DMA request |
| intrOut | output | 1 | Interrupt to the host |
| svcBit | output | 1 | Current service bit |
| fillLevel | output | 5 | Bytes held in the FIFO, 0 to 16 |

## Verification
The directed part of the test does several things:
- It fills the FIFO past 16 bytes so that a drop of an overflow byte is told apart from corrupted ordering.
- It drains one byte past empty to separate a held output from a stale pop.
- It walks the fill level across the 12-code edge, then compares codes 0, 15 and 14 to tell the 16-as-15 rule apart from a plain subtraction.

The terminal-count cases cover three acknowledge patterns: an acknowledge edge, an acknowledge held with a read, and an acknowledge held without a read. This shows that only the first two drop the request. A software clear that collides with a terminal count shows which one wins.

Random traffic then mixes both modes and all threshold codes against a queue model. This exercises simultaneous push and pop at both the full and the empty boundary.

// File: rtl/revFifoPkg.sv
`timescale 1ns/1ps
package revFifoPkg;
  // strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/revFifoStore.sv
`timescale 1ns/1ps
module revFifoStore
  import revFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  p_push_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |=> count == CW'($past(count) + CW'(1)));
  p_pop_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push) |=> count == CW'($past(count) - CW'(1)));
  p_hold_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/revFifoCtrl.sv
`timescale 1ns/1ps
module revFifoCtrl
  import revFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CW-1:0]    count,
  input  logic             periphWr,
  input  logic             hostRd,
  input  logic             dmaEn,
  input  logic             dmaAck,
  input  logic             termCnt,
  input  logic             svcWe,
  input  logic             svcWd,
  input  logic [THR_W-1:0] thr,
  output fifoStrobe_t      strobe,
  output logic             dmaReq,
  output logic             intrOut,
  output logic             svcBit
);
  logic ackQ, tcFlag, tcHit, nonEmpty, full, thrHit;
  logic [THR_W-1:0] thrEff;
  logic [CW-1:0] needCnt;

  assign nonEmpty    = (count != '0);
  assign full        = (count == CW'(DEPTH));
  assign strobe.push = periphWr & ~full;
  assign strobe.pop  = hostRd & nonEmpty;

  // terminal count on an acknowledge edge, or on a read while acknowledge is held
  assign tcHit = dmaEn & termCnt & dmaAck & (~ackQ | hostRd);

  // code 0 stands for 16, which behaves as 15
  assign thrEff  = (thr == '0) ? THR_W'(DEPTH - 1) : thr;
  assign needCnt = CW'(DEPTH) - CW'(thrEff);
  assign thrHit  = ~dmaEn & ~svcBit & (count >= needCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ   <= 1'b0;
      svcBit <= 1'b0;
      tcFlag <= 1'b0;
    end else begin
      ackQ <= dmaAck;
      if (tcHit) begin
        svcBit <= 1'b1;
        tcFlag <= 1'b1;
      end else if (svcWe) begin
        svcBit <= svcWd;
        if (!svcWd) tcFlag <= 1'b0;
      end
    end
  end

  assign dmaReq  = dmaEn & ~svcBit & nonEmpty;
  assign intrOut = tcFlag | thrHit;

  p_tc_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEn && termCnt && dmaAck && hostRd) |=> (svcBit && !dmaReq));
  p_tc_intr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEn && termCnt && dmaAck && hostRd) |=> intrOut);
  p_svc_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (svcBit && !tcFlag) |-> !intrOut);
endmodule

// File: rtl/revFifoService.sv
`timescale 1ns/1ps
module revFifoService
  import revFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphWr,
  input  logic [DW-1:0]    periphData,
  input  logic             hostRd,
  output logic [DW-1:0]    hostData,
  input  logic             dmaEn,
  input  logic             dmaAck,
  input  logic             termCnt,
  input  logic             svcWe,
  input  logic             svcWd,
  input  logic [THR_W-1:0] thr,
  output logic             dmaReq,
  output logic             intrOut,
  output logic             svcBit,
  output logic [CW-1:0]    fillLevel
);
  fifoStrobe_t strobe;

  revFifoCtrl #(.DEPTH(DEPTH), .THR_W(THR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .count(fillLevel), .periphWr(periphWr),
    .hostRd(hostRd), .dmaEn(dmaEn), .dmaAck(dmaAck), .termCnt(termCnt),
    .svcWe(svcWe), .svcWd(svcWd), .thr(thr), .strobe(strobe),
    .dmaReq(dmaReq), .intrOut(intrOut), .svcBit(svcBit)
  );

  revFifoStore #(.DEPTH(DEPTH), .DW(DW)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(periphData),
    .rdData(hostData), .count(fillLevel)
  );
endmodule

// File: tb/sim_revFifoService.sv
`timescale 1ns/1ps
module sim_revFifoService;
  logic clk = 1'b0, rstN = 1'b0;
  logic periphWr = 0, hostRd = 0, dmaEn = 0, dmaAck = 0, termCnt = 0;
  logic svcWe = 0, svcWd = 0;
  logic [7:0] periphData = 0;
  logic [3:0] thr = 4'd12;
  logic [7:0] hostData;
  logic dmaReq, intrOut, svcBit;
  logic [4:0] fillLevel;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  revFifoService u0 (.*);

  // ---- reference model, built from the requirements ----
  byte unsigned q[$];
  byte unsigned mData;
  bit mSvc, mFlag, mAckQ;

  function automatic int needOf(input logic [3:0] t);
    return 16 - ((t == 0) ? 15 : int'(t));   // R7, R8
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mData = 0; mSvc = 0; mFlag = 0; mAckQ = 0;
    end else begin
      bit tc, popOk, pushOk;
      tc     = dmaEn && termCnt && dmaAck && (!mAckQ || hostRd);
      popOk  = hostRd && q.size() > 0;
      pushOk = periphWr && q.size() < 16;
      if (popOk) mData = q.pop_front();
      if (pushOk) q.push_back(periphData);
      if (tc) begin mSvc = 1; mFlag = 1; end
      else if (svcWe) begin mSvc = svcWd; if (!svcWd) mFlag = 0; end
      mAckQ = dmaAck;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int n;
    bit expReq, expIntr;
    n = q.size();
    expReq  = dmaEn && !mSvc && n > 0;
    expIntr = mFlag || (!dmaEn && !mSvc && n >= needOf(thr));
    chk("R2 fillLevel", int'(fillLevel), n);
    chk("R3 hostData", int'(hostData), int'(mData));
    chk("R4 dmaReq", int'(dmaReq), int'(expReq));
    chk("R7 intrOut", int'(intrOut), int'(expIntr));
    chk("R11 svcBit", int'(svcBit), int'(mSvc));
  endtask

  task automatic step(input bit wr, input byte unsigned d, input bit rd,
                      input bit ack, input bit tc, input bit we, input bit wd);
    periphWr = wr; periphData = d; hostRd = rd; dmaAck = ack;
    termCnt = tc; svcWe = we; svcWd = wd;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fillLevel", int'(fillLevel), 0);
    chk("R1 hostData", int'(hostData), 0);
    chk("R1 dmaReq", int'(dmaReq), 0);
    chk("R1 intrOut", int'(intrOut), 0);
    chk("R1 svcBit", int'(svcBit), 0);
    rstN = 1;

    // R7 threshold 12 -> 4 bytes
    for (int i = 1; i <= 3; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    chk("R7 below 4", int'(intrOut), 0);
    step(1, 8'd4, 0, 0, 0, 0, 0);
    chk("R7 at 4", int'(intrOut), 1);
    // R2 overflow drop
    for (int i = 5; i <= 20; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    chk("R2 full", int'(fillLevel), 16);
    for (int i = 1; i <= 16; i++) begin
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R2 order", int'(hostData), i);
    end
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R3 empty hold data", int'(hostData), 16);
    chk("R3 empty hold count", int'(fillLevel), 0);

    // R8 code 0 == 15
    thr = 4'd0;
    step(1, 8'h55, 0, 0, 0, 0, 0);
    chk("R8 thr0 one byte", int'(intrOut), 1);
    thr = 4'd15; step(0, 0, 0, 0, 0, 0, 0);
    chk("R8 thr15 one byte", int'(intrOut), 1);
    thr = 4'd14; step(0, 0, 0, 0, 0, 0, 0);
    chk("R7 thr14 one byte", int'(intrOut), 0);
    thr = 4'd0;
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R11 svc write", int'(svcBit), 1);
    chk("R9 suppressed", int'(intrOut), 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 svc clear", int'(svcBit), 0);

    // DMA mode
    dmaEn = 1;
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R4 req with data", int'(dmaReq), 1);
    step(0, 0, 1, 1, 0, 0, 0);
    chk("R4 req drops empty", int'(dmaReq), 0);
    chk("R3 dma read data", int'(hostData), 8'h55);
    step(1, 8'h66, 0, 0, 0, 0, 0);
    chk("R4 req returns", int'(dmaReq), 1);
    step(1, 8'h67, 0, 0, 0, 0, 0);
    step(1, 8'h68, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0);
    chk("R5 tc svc", int'(svcBit), 1);
    chk("R5 tc req", int'(dmaReq), 0);
    chk("R10 tc intr", int'(intrOut), 1);
    step(1, 8'h69, 0, 0, 0, 0, 0);
    chk("R6 stays low", int'(dmaReq), 0);
    chk("R6 count", int'(fillLevel), 3);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 rearm req", int'(dmaReq), 1);
    chk("R10 intr cleared", int'(intrOut), 0);
    // held acknowledge
    step(0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    chk("R5 held ack no read", int'(svcBit), 0);
    step(0, 0, 1, 1, 1, 0, 0);
    chk("R5 held ack read", int'(svcBit), 1);
    chk("R5 held ack req", int'(dmaReq), 0);
    step(0, 0, 1, 1, 1, 1, 0);
    chk("R10 tc beats clear", int'(svcBit), 1);
    step(0, 0, 0, 0, 0, 1, 0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        dmaEn = 1'($urandom_range(0, 1));
        thr   = 4'($urandom_range(0, 15));
      end
      step(1'($urandom_range(0, 99) < 55), 8'($urandom), 1'($urandom_range(0, 99) < 45),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 19) == 0),
           1'($urandom_range(0, 24) == 0), 1'($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule